// File: doc/BRIEF.md
# Modbus RTU Request Frame Receiver

This block sits behind a byte-wide UART receiver and turns its stream of received characters into checked Modbus RTU request frames. A frame has a fixed field order: the station address byte, then the function code byte, then zero or more data bytes, then a 16-bit CRC. The block has no separate delimiter on the wire. It finds where a frame ends by measuring how long the line stays silent between characters. Both silence thresholds are derived from the system clock, the baud rate and the number of bits per character. The default setup is 19200 baud with 11-bit characters.

As bytes arrive, the block filters them on the station address and runs a CRC-16 over them. It stores the function code and payload in a local buffer. When the line has been silent for 3.5 character times, the block decides the fate of the frame. A frame that passes every check is offered to the user logic with a valid/accept handshake. The offer carries the function code, the payload length and a broadcast flag, and a combinational read port returns the payload bytes. A frame whose CRC does not match is dropped with a one-cycle error pulse. Every other reject is dropped silently.

Top module: `rtu_frame_rx`

## Requirements
- R1: A frame whose first byte is neither `station_addr` nor 0 is ignored. It produces no `frm_valid` and no `crc_err`.
- R2: A frame whose first byte is 0 is accepted as a broadcast. It is presented with `frm_bcast` = 1. An addressed frame is presented with `frm_bcast` = 0.
- R3: The CRC is CRC-16 with the reflected polynomial 0xA001 and start value 0xFFFF, taken over every byte before the CRC field. The CRC is sent low byte first. A frame that passes is presented with `frm_func` equal to its second byte and `frm_len` equal to the total byte count minus 4.
- R4: A frame that fails only its CRC is discarded and raises `crc_err` for exactly one cycle. Frames rejected under R1, R5, R7, R8 or R10 raise no `crc_err`.
- R5: If the silence between two bytes inside a frame is longer than 1.5 character times, the frame is corrupt. It is discarded silently when the line has been quiet for 3.5 character times.
- R6: One character time is BITS_PER_CHAR x (CLK_HZ / BAUD) clocks. A frame is closed only after 3.5 character times of silence following its last byte, and `frm_valid` does not rise before then.
- R7: After reset, every byte that arrives before the line has been idle for 3.5 character times is dropped, together with any frame it belongs to.
- R8: A frame of fewer than 4 bytes, or of more than MAX_FRAME (256) bytes, is discarded silently. A 256-byte frame is accepted.
- R9: `frm_valid` stays high, and `frm_func`, `frm_len` and `frm_bcast` stay stable, until a cycle with `frm_ack` high. `frm_valid` is low in the cycle after that.
- R10: A frame that starts while an earlier frame is still offered is discarded. The offered frame and its payload stay unchanged.
- R11: During and right after reset, `frm_valid` and `crc_err` are low.
- R12: While `frm_valid` is high, `rd_data` returns data byte `rd_idx` of the frame in the same cycle. Index 0 is the first byte after the function code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_addr | input | 8 | Address this station answers to |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| frm_valid | output | 1 | A checked frame is being offered |
| frm_ack | input | 1 | Consumer takes the offered frame |
| frm_func | output | 8 | Function code of the offered frame |
| frm_len | output | 9 | Number of data bytes in the offered frame |
| frm_bcast | output | 1 | Offered frame was a broadcast (no reply expected) |
| rd_idx | input | 8 | Data byte index to read |
| rd_data | output | 8 | Data byte at `rd_idx` |
| crc_err | output | 1 | One-cycle pulse on a CRC mismatch |

## Verification
Two conditions are hardest to reach from the ports. The first is a corrupt frame whose internal gap falls between the two silence thresholds: it must vanish with no error pulse, while a frame with the same bytes and normal spacing is accepted. The bench reaches it by holding the line quiet for a chosen number of cycles in the middle of an otherwise valid frame. The second is a new frame arriving while an earlier one is still unaccepted. The bench withholds `frm_ack`, sends a full, valid second frame, and then reads back the first frame's fields and payload to confirm that nothing was overwritten. Both length edges are also covered: a 256-byte frame and a 257-byte frame with correct CRCs are sent as directed cases.

// File: rtl/rtu_rx_pkg.sv
package rtu_rx_pkg;

   typedef enum logic [1:0] {
      ST_QUIET,
      ST_READY,
      ST_RECV
   } rx_state_t;

   localparam logic [15:0] CRC_POLY = 16'hA001;
   localparam logic [15:0] CRC_SEED = 16'hFFFF;

   // one reflected shift step of the CRC for a single input bit
   function automatic logic [15:0] crc16_bit(input logic [15:0] c, input logic b);
      logic [15:0] x;
      x = c ^ {15'd0, b};
      return x[0] ? ((x >> 1) ^ CRC_POLY) : (x >> 1);
   endfunction

endpackage

// File: rtl/rtu_gap_timer.sv
module rtu_gap_timer #(
   parameter int T15 = 165,
   parameter int T35 = 385
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pulse,
   output logic gap_long,
   output logic quiet,
   output logic eof_tick
);
   localparam int CW = $clog2(T35 + 1);

   initial begin
      assert (T15 >= 1 && T35 > T15)
         else $error("rtu_gap_timer: need 1 <= T15 < T35");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (pulse)             cnt <= '0;
      else if (cnt != CW'(T35))   cnt <= cnt + 1'b1;
   end

   assign gap_long = (cnt >= CW'(T15));
   assign quiet    = (cnt == CW'(T35));
   assign eof_tick = !pulse && (cnt == CW'(T35 - 1));

   assert_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eof_tick |=> quiet);

   assert_gap_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |-> gap_long);

endmodule

// File: rtl/rtu_crc16.sv
module rtu_crc16 import rtu_rx_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        en,
   input  logic [7:0]  data,
   output logic [15:0] crc
);
   logic [15:0] seed;
   logic [15:0] next;

   assign seed = init ? CRC_SEED : crc;

   // bit-serial chain, least significant bit first
   for (genvar i = 0; i < 8; i++) begin : g_bit
      logic [15:0] s_in;
      logic [15:0] s_out;
      if (i == 0) begin : g_first
         assign s_in = seed;
      end else begin : g_next
         assign s_in = g_bit[i-1].s_out;
      end
      assign s_out = crc16_bit(s_in, data[i]);
   end

   assign next = g_bit[7].s_out;

   always_ff @(posedge clk) begin
      if (!rst_n)    crc <= CRC_SEED;
      else if (en)   crc <= next;
      else if (init) crc <= CRC_SEED;
   end

endmodule

// File: rtl/rtu_frame_store.sv
module rtu_frame_store #(
   parameter int DEPTH = 256,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   initial begin
      assert (DEPTH >= 2 && DW >= 1)
         else $error("rtu_frame_store: bad geometry");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/rtu_frame_rx.sv
module rtu_frame_rx import rtu_rx_pkg::*; #(
   parameter int CLK_HZ        = 50_000_000,
   parameter int BAUD          = 19200,
   parameter int BITS_PER_CHAR = 11,
   parameter int MAX_FRAME     = 256,
   localparam int AW           = $clog2(MAX_FRAME),
   localparam int LW           = $clog2(MAX_FRAME + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    station_addr,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   output logic          frm_valid,
   input  logic          frm_ack,
   output logic [7:0]    frm_func,
   output logic [LW-1:0] frm_len,
   output logic          frm_bcast,
   input  logic [AW-1:0] rd_idx,
   output logic [7:0]    rd_data,
   output logic          crc_err
);
   localparam int CHAR_CYC = (CLK_HZ / BAUD) * BITS_PER_CHAR;
   localparam int T15      = (CHAR_CYC * 3) / 2;
   localparam int T35      = (CHAR_CYC * 7) / 2;
   localparam int CNTW     = LW;
   localparam int MIN_LEN  = 4;

   initial begin
      assert (MAX_FRAME >= MIN_LEN && MAX_FRAME <= 4096)
         else $error("rtu_frame_rx: MAX_FRAME out of range");
      assert (BAUD > 0 && CLK_HZ / BAUD >= 2)
         else $error("rtu_frame_rx: clock too slow for baud rate");
      assert (BITS_PER_CHAR >= 10 && BITS_PER_CHAR <= 12)
         else $error("rtu_frame_rx: BITS_PER_CHAR must be 10..12");
   end

   rx_state_t       state;
   logic [CNTW-1:0] count;
   logic            keep, bcast, bad, over, blocked;
   logic [7:0]      func_q;

   logic            gap_long, quiet, eof_tick;
   logic [15:0]     crc_val;
   logic            crc_init, crc_en;
   logic            at_limit, take_byte, store_we, frame_ok;
   logic [AW-1:0]   waddr, raddr;

   rtu_gap_timer #(.T15(T15), .T35(T35)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse    (rx_valid),
      .gap_long (gap_long),
      .quiet    (quiet),
      .eof_tick (eof_tick)
   );

   // byte bookkeeping
   assign at_limit  = (count == CNTW'(MAX_FRAME));
   assign take_byte = (state == ST_RECV) && rx_valid && !gap_long && !at_limit;
   assign crc_init  = (state == ST_READY);
   assign crc_en    = ((state == ST_READY) && rx_valid) || take_byte;
   assign store_we  = take_byte && keep && !blocked;
   assign waddr     = AW'(count - CNTW'(1));
   assign raddr     = rd_idx + AW'(1);
   assign frame_ok  = keep && !blocked && !bad && !over && (count >= CNTW'(MIN_LEN));

   rtu_crc16 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .en    (crc_en),
      .data  (rx_data),
      .crc   (crc_val)
   );

   rtu_frame_store #(.DEPTH(MAX_FRAME), .DW(8)) u_store (
      .clk   (clk),
      .we    (store_we),
      .waddr (waddr),
      .wdata (rx_data),
      .raddr (raddr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_QUIET;
         count     <= '0;
         keep      <= 1'b0;
         bcast     <= 1'b0;
         bad       <= 1'b0;
         over      <= 1'b0;
         blocked   <= 1'b0;
         func_q    <= '0;
         frm_valid <= 1'b0;
         frm_func  <= '0;
         frm_len   <= '0;
         frm_bcast <= 1'b0;
         crc_err   <= 1'b0;
      end else begin
         crc_err <= 1'b0;
         if (frm_valid && frm_ack) frm_valid <= 1'b0;

         unique case (state)
            ST_QUIET: begin
               if (quiet && !rx_valid) state <= ST_READY;
            end
            ST_READY: begin
               if (rx_valid) begin
                  state   <= ST_RECV;
                  count   <= CNTW'(1);
                  keep    <= (rx_data == station_addr) || (rx_data == 8'd0);
                  bcast   <= (rx_data == 8'd0);
                  bad     <= 1'b0;
                  over    <= 1'b0;
                  blocked <= frm_valid;
               end
            end
            ST_RECV: begin
               if (rx_valid) begin
                  if (gap_long) begin
                     bad <= 1'b1;
                  end else if (at_limit) begin
                     over <= 1'b1;
                  end else begin
                     count <= count + 1'b1;
                     if (count == CNTW'(1)) func_q <= rx_data;
                  end
               end else if (eof_tick) begin
                  state <= ST_READY;
                  if (frame_ok) begin
                     if (crc_val == 16'h0000) begin
                        frm_valid <= 1'b1;
                        frm_func  <= func_q;
                        frm_len   <= LW'(count - CNTW'(MIN_LEN));
                        frm_bcast <= bcast;
                     end else begin
                        crc_err <= 1'b1;
                     end
                  end
               end
            end
            default: state <= ST_QUIET;
         endcase
      end
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !frm_ack |=> frm_valid && $stable(frm_func)
                                && $stable(frm_len) && $stable(frm_bcast));

   assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |=> !crc_err);

   assert_err_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(crc_err && $rose(frm_valid)));

   assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> (frm_len <= LW'(MAX_FRAME - MIN_LEN)));

   assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      store_we |-> !frm_valid);

   assert_quiet_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_QUIET) |=> !$rose(frm_valid));

endmodule

// File: tb/sim_rtu_frame_rx.sv
module sim_rtu_frame_rx;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 192_000;
   localparam int BAUD       = 19200;
   localparam int BITS       = 11;
   localparam int MAXF       = 256;
   localparam int CHARC      = (CLK_HZ / BAUD) * BITS;
   localparam int T35C       = (CHARC * 7) / 2;
   localparam logic [7:0] MY_ADDR = 8'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       frm_valid, frm_bcast, crc_err;
   logic       frm_ack = 1'b0;
   logic [7:0] frm_func, rd_data;
   logic [8:0] frm_len;
   logic [7:0] rd_idx = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rtu_frame_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .BITS_PER_CHAR(BITS), .MAX_FRAME(MAXF)) u0 (
      .clk(clk), .rst_n(rst_n), .station_addr(MY_ADDR),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .frm_valid(frm_valid), .frm_ack(frm_ack), .frm_func(frm_func),
      .frm_len(frm_len), .frm_bcast(frm_bcast),
      .rd_idx(rd_idx), .rd_data(rd_data), .crc_err(crc_err)
   );

   int checks = 0;
   int errors = 0;
   int pubs = 0;
   int errp = 0;
   int cyc = 0;
   logic prev_v = 1'b0;
   logic [7:0] fb [0:299];
   logic [7:0] dexp [0:299];
   int fn = 0;

   // event monitor, sampled on the falling edge
   always @(negedge clk) begin
      if (crc_err) errp++;
      if (frm_valid && !prev_v) pubs++;
      prev_v = frm_valid;
   end

   always @(negedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         errors++;
         checks++;
         $display("FAIL R6 watchdog actual=%0d expected=<190000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input int n);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {8'd0, fb[i]};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
      end
      return c;
   endfunction

   task automatic build(input logic [7:0] addr, input logic [7:0] func, input int nd, input bit bad_crc);
      logic [15:0] c;
      fb[0] = addr;
      fb[1] = func;
      for (int i = 0; i < nd; i++) begin
         dexp[i] = 8'($urandom);
         fb[2 + i] = dexp[i];
      end
      fn = 2 + nd;
      c = ref_crc(fn);
      fb[fn]     = c[7:0] ^ {7'd0, bad_crc};
      fb[fn + 1] = c[15:8];
      fn = fn + 2;
   endtask

   task automatic put_byte(input logic [7:0] b, input int gap);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   // long_at: index of the byte followed by a long silence, -1 for none
   task automatic send(input int gap_max, input int long_at);
      for (int i = 0; i < fn; i++) begin
         if (i == fn - 1)       put_byte(fb[i], 0);
         else if (i == long_at) put_byte(fb[i], 250);
         else                   put_byte(fb[i], int'($urandom_range(gap_max, 0)));
      end
   endtask

   task automatic settle();
      repeat (T35C + 30) @(negedge clk);
   endtask

   task automatic check_frame(input string tag, input logic [7:0] func, input int nd, input bit bc);
      int bad_bytes = 0;
      int first_bad = -1;
      chk(frm_valid == 1'b1, tag, frm_valid, 1);
      chk(frm_func == func, tag, frm_func, func);
      chk(int'(frm_len) == nd, tag, frm_len, nd);
      chk(frm_bcast == bc, tag, frm_bcast, bc);
      for (int i = 0; i < nd; i++) begin
         rd_idx = 8'(i);
         #1;
         if (rd_data !== dexp[i]) begin
            bad_bytes++;
            if (first_bad < 0) first_bad = i;
         end
      end
      chk(bad_bytes == 0, "R12 payload", first_bad, -1);
   endtask

   task automatic do_ack();
      @(negedge clk);
      frm_ack = 1'b1;
      @(negedge clk);
      frm_ack = 1'b0;
      chk(frm_valid == 1'b0, "R9 clear after ack", frm_valid, 0);
   endtask

   // full case: send, wait for the close, compare events and contents
   task automatic run_case(input string tag, input logic [7:0] addr, input int nd,
                           input bit bad_crc, input int gap_max, input int long_at,
                           input bit exp_pub, input bit exp_err);
      int p0, e0;
      logic [7:0] func;
      func = 8'($urandom_range(127, 1));
      build(addr, func, nd, bad_crc);
      p0 = pubs;
      e0 = errp;
      send(gap_max, long_at);
      settle();
      chk((pubs - p0) == int'(exp_pub), {tag, " frame offered"}, pubs - p0, exp_pub);
      chk((errp - e0) == int'(exp_err), {tag, " crc_err pulses"}, errp - e0, exp_err);
      if (exp_pub) begin
         check_frame(tag, func, nd, addr == 8'd0);
         do_ack();
      end
   endtask

   initial begin
      void'($urandom(32'd20190314));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(frm_valid == 1'b0, "R11 reset frm_valid", frm_valid, 0);
      chk(crc_err == 1'b0, "R11 reset crc_err", crc_err, 0);

      // R7: valid frame sent right after reset must be dropped
      run_case("R7 early frame", MY_ADDR, 3, 1'b0, 20, -1, 1'b0, 1'b0);

      // R6 timing plus R3 and R9 on a basic addressed frame
      begin
         int p0;
         logic [7:0] func = 8'h03;
         build(MY_ADDR, func, 4, 1'b0);
         p0 = pubs;
         send(20, -1);
         repeat (T35C - 100) @(negedge clk);
         chk(frm_valid == 1'b0, "R6 not closed before 3.5 chars", frm_valid, 0);
         repeat (130) @(negedge clk);
         chk(pubs - p0 == 1, "R6 closed after 3.5 chars", pubs - p0, 1);
         check_frame("R3 basic frame", func, 4, 1'b0);
         repeat (60) @(negedge clk);
         chk(frm_valid == 1'b1 && frm_func == func, "R9 hold without ack", frm_func, func);
         do_ack();
      end

      run_case("R1 foreign address", 8'h17, 5, 1'b0, 20, -1, 1'b0, 1'b0);
      run_case("R2 broadcast", 8'h00, 2, 1'b0, 20, -1, 1'b1, 1'b0);
      run_case("R4 bad crc", MY_ADDR, 6, 1'b1, 20, -1, 1'b0, 1'b1);
      run_case("R1 bad crc foreign", 8'h55, 6, 1'b1, 20, -1, 1'b0, 1'b0);
      run_case("R5 long gap", MY_ADDR, 6, 1'b0, 20, 3, 1'b0, 1'b0);
      run_case("R5 same frame spaced ok", MY_ADDR, 6, 1'b0, 20, -1, 1'b1, 1'b0);
      run_case("R3 empty payload", MY_ADDR, 0, 1'b0, 20, -1, 1'b1, 1'b0);

      // R8: three-byte frame with a self-consistent CRC
      begin
         int p0, e0;
         logic [15:0] c;
         fb[0] = MY_ADDR;
         c = ref_crc(1);
         fb[1] = c[7:0];
         fb[2] = c[15:8];
         fn = 3;
         p0 = pubs;
         e0 = errp;
         send(10, -1);
         settle();
         chk(pubs == p0 && errp == e0, "R8 short frame dropped", pubs - p0, 0);
      end

      run_case("R8 max length", MY_ADDR, MAXF - 4, 1'b0, 4, -1, 1'b1, 1'b0);
      run_case("R8 over length", MY_ADDR, MAXF - 3, 1'b0, 4, -1, 1'b0, 1'b0);

      // R10: second frame while the first is still offered
      begin
         int p0;
         logic [7:0] f1 = 8'h10;
         logic [7:0] keep_d [0:7];
         build(MY_ADDR, f1, 8, 1'b0);
         for (int i = 0; i < 8; i++) keep_d[i] = dexp[i];
         p0 = pubs;
         send(20, -1);
         settle();
         chk(pubs - p0 == 1, "R10 first frame offered", pubs - p0, 1);
         build(MY_ADDR, 8'h06, 3, 1'b0);
         send(20, -1);
         settle();
         chk(pubs - p0 == 1, "R10 second frame dropped", pubs - p0, 1);
         for (int i = 0; i < 8; i++) dexp[i] = keep_d[i];
         check_frame("R10 first frame intact", f1, 8, 1'b0);
         do_ack();
      end
      run_case("R10 accepted after ack", MY_ADDR, 3, 1'b0, 20, -1, 1'b1, 1'b0);

      // random mix of addresses, lengths and CRC faults
      for (int it = 0; it < 24; it++) begin
         int sel = int'($urandom_range(2, 0));
         logic [7:0] a = (sel == 0) ? MY_ADDR : (sel == 1) ? 8'h00 : 8'(MY_ADDR + 1 + $urandom_range(100, 0));
         bit bc = ($urandom_range(3, 0) == 0);
         bit mine = (sel != 2);
         run_case((sel == 2) ? "R1 random" : (bc ? "R4 random" : "R3 random"),
                  a, int'($urandom_range(16, 0)), bc, 30, -1, mine && !bc, mine && bc);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule